// File: doc/BRIEF.md
# Programmable Soft Decision Slicer

This block turns pairs of signed baseband samples (I and Q) into soft-decision symbols for a downstream decoder. It takes the magnitude of each channel and counts how many of three evenly spaced decision levels that magnitude reaches. The three levels are one, two and three times a single programmed threshold. Each output symbol is three bits wide: a sign bit followed by a two-bit confidence level.

Both channels are sliced separately, using the same thresholds and the same output encoding. An 8-bit configuration word supplies the threshold and selects the encoding. The encoding is either sign/magnitude or two's complement. Samples are fractional, with the value equal to the signed integer divided by 2^(SAMPLE_W-1), so magnitudes run from 0.0 to just under 1.0. Thresholds above about one third leave the upper levels out of reach.

The block samples inputs and configuration together on each strobed cycle. It returns the symbols one clock later, with a matching valid strobe.

Top module: `soft_slicer`

## Requirements
- R1: Configuration bit 7 selects the output encoding: 0 gives sign/magnitude and 1 gives two's complement.
- R2: Configuration bits 6..0 form an unsigned fraction, with bit 6 weighted 2^-1 down to bit 0 weighted 2^-7. In sample units the threshold T equals code * 2^(SAMPLE_W-8).
- R3: The level is the number of values in {T, 2T, 3T} that the channel magnitude is greater than or equal to (0 to 3). When the code is 0, every sample gives level 3.
- R4: The magnitude of the most negative input saturates to 2^(SAMPLE_W-1)-1. Every other input gives its exact absolute value.
- R5: In sign/magnitude mode the symbol is {sign, level}, where sign is 1 for a negative input. This holds at level 0 as well.
- R6: In two's complement mode the symbol is the 3-bit value -level for a negative input and +level otherwise. Level 0 gives 000, and 100 never appears.
- R7: 2T and 3T are formed at a width that cannot overflow. With code 127, no magnitude reaches level 2 or 3.
- R8: I and Q are sliced independently with the same thresholds and the same encoding.
- R9: Symbols are registered with one clock of latency, and out_valid is in_valid delayed by one clock. Reset clears out_valid and both symbols to 000.
- R10: While in_valid is low, both symbols hold their last values, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| i_sample | input | SAMPLE_W | Signed I sample |
| q_sample | input | SAMPLE_W | Signed Q sample |
| cfg_word | input | 8 | Bit 7 selects the encoding; bits 6..0 hold the threshold code |
| out_valid | output | 1 | Symbol strobe |
| i_sym | output | 3 | I soft symbol |
| q_sym | output | 3 | Q soft symbol |

## Verification
The bench builds two copies of the block, one at the default SAMPLE_W of 12 and one at SAMPLE_W of 8. Both receive the same strobe and configuration. The narrow copy receives the upper eight bits of each sample.

At width 8 the threshold code lines up with the sample bits without any shift. At width 12 it is shifted up by four bits. Running both exercises each alignment. Directed values sit one below and exactly at T, 2T and 3T in both widths, and they include the saturating most negative input. Long randomised runs with a gapped strobe cover both encodings and the hold behaviour.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  localparam int CFG_W   = 8;
  localparam int THR_W   = 7;
  localparam int FMT_BIT = 7;
  localparam int NUM_THR = 3;
  localparam int LVL_W   = 2;
  localparam int SYM_W   = LVL_W + 1;
  localparam int NUM_CH  = 2;

  typedef enum logic {
    FMT_SIGN_MAG = 1'b0,
    FMT_TWOS     = 1'b1
  } fmt_e;
endpackage

// File: rtl/threshold_gen.sv
// Builds the 1x..NUM_THR x decision levels from the 7-bit fractional code.
// Each level is the previous one plus the base, at two extra bits of width.
module threshold_gen
  import slicer_pkg::*;
#(
  parameter int MAG_W = 11,
  parameter int CMP_W = MAG_W + 2
) (
  input  logic [THR_W-1:0]              thr_code,
  output logic [NUM_THR-1:0][CMP_W-1:0] thr_lvls
);
  localparam int SHIFT = MAG_W - THR_W;

  logic [CMP_W-1:0] base;
  assign base = CMP_W'(thr_code) << SHIFT;

  for (genvar k = 0; k < NUM_THR; k++) begin : g_lvl
    if (k == 0) begin : g_first
      assign thr_lvls[k] = base;
    end else begin : g_next
      assign thr_lvls[k] = thr_lvls[k-1] + base;
    end
  end
endmodule

// File: rtl/mag_extract.sv
// Absolute value with saturation of the most negative code.
module mag_extract #(
  parameter int SAMPLE_W = 12,
  parameter int MAG_W    = SAMPLE_W - 1
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic        [MAG_W-1:0]    mag,
  output logic                       neg
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic signed [SAMPLE_W-1:0] negated;
  assign negated = -sample;

  always_comb begin
    neg = sample[SAMPLE_W-1];
    if (sample == MOST_NEG) begin
      mag = '1;
    end else if (neg) begin
      mag = negated[MAG_W-1:0];
    end else begin
      mag = sample[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/level_compare.sv
// Counts how many decision levels the magnitude meets or exceeds.
module level_compare
  import slicer_pkg::*;
#(
  parameter int CMP_W = 13
) (
  input  logic [CMP_W-1:0]              mag_ext,
  input  logic [NUM_THR-1:0][CMP_W-1:0] thr_lvls,
  output logic [LVL_W-1:0]              lvl
);
  always_comb begin
    lvl = '0;
    for (int k = 0; k < NUM_THR; k++) begin
      if (mag_ext >= thr_lvls[k]) begin
        lvl = lvl + LVL_W'(1);
      end
    end
  end
endmodule

// File: rtl/symbol_encode.sv
// Packs sign and level into the selected output format.
module symbol_encode
  import slicer_pkg::*;
(
  input  logic             neg,
  input  logic [LVL_W-1:0] lvl,
  input  fmt_e             fmt,
  output logic [SYM_W-1:0] sym
);
  logic [SYM_W-1:0] pos_val;
  assign pos_val = {1'b0, lvl};

  always_comb begin
    unique case (fmt)
      FMT_SIGN_MAG: sym = {neg, lvl};
      FMT_TWOS: begin
        if (neg && (lvl != '0)) begin
          sym = (~pos_val) + SYM_W'(1);
        end else begin
          sym = pos_val;
        end
      end
      default: sym = '0;
    endcase
  end
endmodule

// File: rtl/soft_slicer.sv
module soft_slicer
  import slicer_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic signed [SAMPLE_W-1:0] i_sample,
  input  logic signed [SAMPLE_W-1:0] q_sample,
  input  logic [CFG_W-1:0]           cfg_word,
  output logic                       out_valid,
  output logic [SYM_W-1:0]           i_sym,
  output logic [SYM_W-1:0]           q_sym
);
  localparam int MAG_W = SAMPLE_W - 1;
  localparam int CMP_W = MAG_W + 2;
  localparam logic [SYM_W-1:0] NEG_ZERO = {1'b1, {LVL_W{1'b0}}};

  logic [NUM_THR-1:0][CMP_W-1:0] thr_lvls;
  fmt_e                          fmt;
  logic signed [SAMPLE_W-1:0]    samp     [NUM_CH];
  logic [SYM_W-1:0]              sym_next [NUM_CH];
  logic [SYM_W-1:0]              sym_q    [NUM_CH];
  logic                          valid_q;

  assign fmt     = fmt_e'(cfg_word[FMT_BIT]);
  assign samp[0] = i_sample;
  assign samp[1] = q_sample;

  threshold_gen #(.MAG_W(MAG_W), .CMP_W(CMP_W)) u_thr (
    .thr_code (cfg_word[THR_W-1:0]),
    .thr_lvls (thr_lvls)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [MAG_W-1:0] mag;
    logic             neg;
    logic [LVL_W-1:0] lvl;

    mag_extract #(.SAMPLE_W(SAMPLE_W), .MAG_W(MAG_W)) u_mag (
      .sample (samp[ch]),
      .mag    (mag),
      .neg    (neg)
    );

    level_compare #(.CMP_W(CMP_W)) u_cmp (
      .mag_ext  (CMP_W'(mag)),
      .thr_lvls (thr_lvls),
      .lvl      (lvl)
    );

    symbol_encode u_enc (
      .neg (neg),
      .lvl (lvl),
      .fmt (fmt),
      .sym (sym_next[ch])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        sym_q[ch] <= '0;
      end else if (in_valid) begin
        sym_q[ch] <= sym_next[ch];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
    end
  end

  assign out_valid = valid_q;
  assign i_sym     = sym_q[0];
  assign q_sym     = sym_q[1];

  // R9: strobe follows input strobe by one clock
  a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_valid_fall: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R10: no update without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(i_sym) && $stable(q_sym)));

  // R6: two's complement never yields a negative zero
  a_r6_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_word[FMT_BIT]) |=> ((i_sym != NEG_ZERO) && (q_sym != NEG_ZERO)));

  // R5: sign/magnitude keeps the input sign
  a_r5_sign_kept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cfg_word[FMT_BIT]) |=>
      ((i_sym[SYM_W-1] == $past(i_sample[SAMPLE_W-1])) &&
       (q_sym[SYM_W-1] == $past(q_sample[SAMPLE_W-1]))));

  // R3: zero code puts every sample at the top level
  a_r3_zero_thr: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cfg_word[THR_W-1:0] == '0)) |=>
      ((i_sym[LVL_W-1:0] != '0) && (q_sym[LVL_W-1:0] != '0)));
endmodule

// File: tb/tb_soft_slicer.sv
`timescale 1ns/1ps
module tb_soft_slicer;
  localparam int W  = 12;
  localparam int WN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [W-1:0] i_s = '0;
  logic signed [W-1:0] q_s = '0;
  logic [7:0] cfg = '0;
  logic signed [WN-1:0] i_n, q_n;
  assign i_n = i_s[W-1:W-WN];
  assign q_n = q_s[W-1:W-WN];

  logic       ov, ov_n;
  logic [2:0] isym, qsym, isym_n, qsym_n;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  string cur_tag = "R3";
  string tag_q   = "R3";

  always #5 clk = ~clk;

  soft_slicer #(.SAMPLE_W(W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .i_sample(i_s), .q_sample(q_s),
    .cfg_word(cfg), .out_valid(ov), .i_sym(isym), .q_sym(qsym));

  soft_slicer #(.SAMPLE_W(WN)) dut_n (
    .clk(clk), .rst(rst), .in_valid(in_valid), .i_sample(i_n), .q_sample(q_n),
    .cfg_word(cfg), .out_valid(ov_n), .i_sym(isym_n), .q_sym(qsym_n));

  function automatic logic [2:0] ref_sym(input int s, input int c, input int w);
    int mag, maxm, t, lvl;
    maxm = (1 << (w - 1)) - 1;
    mag  = (s < 0) ? -s : s;
    if (mag > maxm) mag = maxm;
    t   = (c % 128) * (1 << (w - 8));
    lvl = 0;
    if (mag >= t)     lvl++;
    if (mag >= 2 * t) lvl++;
    if (mag >= 3 * t) lvl++;
    if (c >= 128) begin
      if (s < 0) return 3'((8 - lvl) % 8);
      return 3'(lvl);
    end
    return {(s < 0), 2'(lvl)};
  endfunction

  logic       e_v = 1'b0;
  logic [2:0] e_i = '0, e_q = '0, e_in = '0, e_qn = '0;

  always @(posedge clk) begin
    if (rst) begin
      e_v <= 1'b0; e_i <= '0; e_q <= '0; e_in <= '0; e_qn <= '0;
    end else begin
      e_v <= in_valid;
      if (in_valid) begin
        e_i   <= ref_sym(int'(i_s), int'(cfg), W);
        e_q   <= ref_sym(int'(q_s), int'(cfg), W);
        e_in  <= ref_sym(int'(i_n), int'(cfg), WN);
        e_qn  <= ref_sym(int'(q_n), int'(cfg), WN);
        tag_q <= cur_tag;
      end
    end
  end

  task automatic check(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check("R9", "out_valid w12", int'(ov), int'(e_v));
      check("R9", "out_valid w8", int'(ov_n), int'(e_v));
      check(tag_q, "i_sym w12", int'(isym), int'(e_i));
      check(tag_q, "q_sym w12", int'(qsym), int'(e_q));
      check(tag_q, "i_sym w8", int'(isym_n), int'(e_in));
      check(tag_q, "q_sym w8", int'(qsym_n), int'(e_qn));
    end
  end

  task automatic drive(input int iv, input int qv, input int c, input bit v, input string tag);
    @(negedge clk);
    i_s = W'(iv); q_s = W'(qv); cfg = 8'(c); in_valid = v; cur_tag = tag;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int vals[16] = '{0, 1, 511, 512, 1023, 1024, 1535, 1536, 2047,
                     -1, -511, -512, -1024, -1536, -2047, -2048};
    int edge3[6] = '{2015, 2016, 2047, -2015, -2016, -2048};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    check("R9", "reset out_valid", int'(ov), 0);
    check("R9", "reset i_sym", int'(isym), 0);
    check("R9", "reset q_sym", int'(qsym), 0);
    rst = 1'b0;
    checking = 1'b1;

    // R3 R4 R5 R2: thresholds at 0.25, sign/magnitude
    foreach (vals[k]) drive(vals[k], -vals[k] - 1, 8'h20, 1'b1, "R3");
    // R1 R6: same values in two's complement
    foreach (vals[k]) drive(vals[k], vals[15 - k], 8'hA0, 1'b1, "R6");
    // R3: zero threshold
    foreach (vals[k]) drive(vals[k], vals[k] / 3, 8'h00, 1'b1, "R3");
    drive(0, -2048, 8'h80, 1'b1, "R3");
    // R7: largest code, 2T and 3T beyond reach
    foreach (vals[k]) drive(vals[k], -vals[k], 8'h7F, 1'b1, "R7");
    drive(2047, -2048, 8'hFF, 1'b1, "R7");
    // R2 R4: 3T just below full scale
    foreach (edge3[k]) drive(edge3[k], -edge3[k], 8'h2A, 1'b1, "R2");
    foreach (edge3[k]) drive(edge3[k], edge3[k], 8'hAA, 1'b1, "R4");
    // R8: channels with different magnitudes
    drive(1536, 0, 8'h20, 1'b1, "R8");
    drive(-5, 1100, 8'hA0, 1'b1, "R8");
    // R10: idle cycles with changing inputs
    drive(-2048, 2047, 8'h00, 1'b0, "R10");
    drive(100, -100, 8'h80, 1'b0, "R10");
    drive(7, 7, 8'h7F, 1'b0, "R10");
    drive(1024, -1024, 8'h20, 1'b1, "R10");
    // random mix, gapped strobe
    for (int n = 0; n < 4000; n++) begin
      int c;
      c = int'($urandom_range(255, 0));
      if ($urandom_range(3, 0) != 0) c = (c & 8'h80) | int'($urandom_range(45, 0));
      drive(int'($urandom_range(4095, 0)) - 2048, int'($urandom_range(4095, 0)) - 2048,
            c, ($urandom_range(3, 0) != 0), (c >= 128) ? "R6" : "R5");
    end
    drive(0, 0, 0, 1'b0, "R10");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule